// File: doc/BRIEF.md
# Package Deep Power-Down Sequencer

This block decides when a two-thread processor package may drop into its deepest power state, and it walks the package in and out of that state. It watches a per-thread flag that says the thread has reached its deepest C-state, and a count of the cache ways that are still active. It also watches four active-low sideband pins that the chipset drives. When every thread is deep and no cache way is left, the block asks the retention memory to save each thread's state. It then waits for the chipset to assert the pins in order. Once the last pin is asserted, it drops the core voltage target to its minimum.

On a break event the chipset releases the pins in reverse order, and the block follows two of those releases. When the deep-sleep pin is released, the voltage target moves to the low-frequency level and the PLL enable is raised. When the sleep pin is released, the core is held in reset for a fixed number of cycles. Restore strobes then go out, one thread per cycle. The package returns to normal operation when the stop-clock pin is released. A pin change that breaks the required order sets a sticky error flag. The sequencer does not move until the pins are back in a legal pattern.

Top module: `pkg_dpd_seq`

## Requirements
- R1: Entry starts only when every bit of `thr_deep` is 1 and `l2_ways` is 0. The cycle after the first clock edge that sees this condition, `save_stb` is 2'b01 (thread 0). The next cycle it is 2'b10 (thread 1). Outside entry it is 0.
- R2: After reset, `vcode` is 2'b10 (normal), `pll_en` is 1, `snoop_ok` is 1, and `core_rst`, `save_stb`, `restore_stb` and `proto_err` are all 0.
- R3: The pin pattern counts as legal only as a prefix of the entry order: none asserted, then stop-clock, then plus sleep, then plus deep-sleep, then plus deep-reset. Only one step up or down is allowed per clock. Any other pattern or jump sets `proto_err` one edge later, and the flag stays set until reset. While the pattern is illegal, the block keeps its last legal level and its outputs do not change.
- R4: After the save, a deep-reset assertion moves the package to the deep state two edges after the pin change. There `vcode` is 2'b00 (minimum, about 0.3 V) and `pll_en` is 0.
- R5: If eligibility is lost during the save or before the deep-reset assertion has been registered, the block returns to normal operation without any restore strobe and with `vcode` held at 2'b10. Later pin assertions do not take it into the deep state.
- R6: In the deep state, releasing deep-sleep sets `vcode` to 2'b01 (low-frequency) and `pll_en` to 1, two edges after the pin change. Releasing only deep-reset leaves `vcode` at 2'b00.
- R7: Releasing sleep raises `core_rst` two edges later. It stays high for exactly RST_CYC cycles (default 4). In the next cycle `restore_stb` is 2'b01, and in the cycle after that it is 2'b10.
- R8: After the restores, releasing stop-clock gives `vcode` 2'b10 and `snoop_ok` 1 two edges later.
- R9: `snoop_ok` is 0 from the deep state until the core reset ends, and 1 otherwise.
- R10: If the registered deep-reset level and a loss of eligibility meet in the same cycle, entry wins. If eligibility drops in the same cycle as the pin change, before it is registered, the entry aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_deep | input | NTHR | Per-thread flag: thread is in its deepest C-state |
| l2_ways | input | WAYW | Number of active cache ways |
| stpclk_n | input | 1 | Stop-clock pin, active low (first asserted) |
| slp_n | input | 1 | Sleep pin, active low |
| dpslp_n | input | 1 | Deep-sleep pin, active low |
| dprst_n | input | 1 | Deep-reset pin, active low (last asserted) |
| vcode | output | 2 | Core voltage target: 00 minimum, 01 low-frequency, 10 normal |
| pll_en | output | 1 | PLL enable |
| save_stb | output | NTHR | Per-thread state-save strobe to the retention memory |
| restore_stb | output | NTHR | Per-thread state-restore strobe from the retention memory |
| core_rst | output | 1 | Core hardware reset |
| snoop_ok | output | 1 | Snoops may be issued or answered |
| proto_err | output | 1 | Sticky pin-order violation flag |

## Verification
Two functions can act in the same cycle: the abort caused by a loss of eligibility, and the deep-state entry caused by the registered deep-reset level. The bench sets up the clash twice. In the first case a thread leaves its deep state one cycle after the deep-reset assertion, so the registered level is already present. In the second case the thread leaves in the same cycle as the pin change. The outcome is judged from `vcode` and `snoop_ok`. Entry should win in the first case and the abort in the second.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [2:0] {
    ST_C0, ST_SAVE, ST_WAIT, ST_PKG, ST_VRAMP, ST_RESET, ST_RESTORE
  } dpd_state_e;

  localparam logic [1:0] VC_MIN  = 2'b00;
  localparam logic [1:0] VC_LFM  = 2'b01;
  localparam logic [1:0] VC_NORM = 2'b10;

  localparam int NPIN = 4;
  localparam logic [2:0] LV_NONE = 3'd0;
  localparam logic [2:0] LV_STP  = 3'd1;
  localparam logic [2:0] LV_SLP  = 3'd2;
  localparam logic [2:0] LV_ALL  = 3'd4;

  // {legal, level}: legal when the asserted set is a prefix of the entry order
  function automatic logic [3:0] pin_level(input logic [NPIN-1:0] asrt);
    logic [3:0] r;
    r = 4'd0;
    for (int k = 0; k <= NPIN; k++) begin
      if (asrt == NPIN'((1 << k) - 1)) r = {1'b1, 3'(k)};
    end
    return r;
  endfunction

  function automatic logic step_ok(input logic [2:0] cur, input logic [2:0] nxt);
    return (nxt == cur) || (nxt == cur + 3'd1) || (cur == nxt + 3'd1);
  endfunction

  function automatic logic [1:0] vcode_of(input dpd_state_e s);
    case (s)
      ST_PKG:                         return VC_MIN;
      ST_VRAMP, ST_RESET, ST_RESTORE: return VC_LFM;
      default:                        return VC_NORM;
    endcase
  endfunction
endpackage

// File: rtl/dpd_pin_track.sv
module dpd_pin_track
  import dpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stpclk_n,
  input  logic       slp_n,
  input  logic       dpslp_n,
  input  logic       dprst_n,
  output logic [2:0] lvl,
  output logic       pin_bad,
  output logic       proto_err
);
  logic [NPIN-1:0] asrt;
  logic [3:0]      lv_now;

  assign asrt    = ~{dprst_n, dpslp_n, slp_n, stpclk_n};
  assign lv_now  = pin_level(asrt);
  assign pin_bad = !lv_now[3] || !step_ok(lvl, lv_now[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl       <= LV_NONE;
      proto_err <= 1'b0;
    end else if (pin_bad) begin
      proto_err <= 1'b1;
    end else begin
      lvl <= lv_now[2:0];
    end
  end

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  a_r3_hold_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    pin_bad |=> (lvl == $past(lvl)) && proto_err);
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> (lvl == $past(lvl) + 3'd1 || lvl + 3'd1 == $past(lvl)));
endmodule

// File: rtl/dpd_elig.sv
module dpd_elig #(
  parameter int NTHR = 2,
  parameter int WAYW = 4
) (
  input  logic [NTHR-1:0] thr_deep,
  input  logic [WAYW-1:0] l2_ways,
  output logic            elig
);
  logic [NTHR:0] chain;
  assign chain[0] = 1'b1;
  for (genvar g = 0; g < NTHR; g++) begin : g_and
    assign chain[g+1] = chain[g] & thr_deep[g];
  end
  assign elig = chain[NTHR] && (l2_ways == '0);
endmodule

// File: rtl/dpd_thr_strobe.sv
module dpd_thr_strobe #(
  parameter int NTHR = 2,
  parameter int CW   = 3
) (
  input  logic            en,
  input  logic [CW-1:0]   idx,
  output logic [NTHR-1:0] stb
);
  for (genvar g = 0; g < NTHR; g++) begin : g_dec
    assign stb[g] = en && (idx == CW'(g));
  end
endmodule

// File: rtl/pkg_dpd_seq.sv
module pkg_dpd_seq
  import dpd_pkg::*;
#(
  parameter int NTHR    = 2,
  parameter int WAYW    = 4,
  parameter int RST_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] thr_deep,
  input  logic [WAYW-1:0] l2_ways,
  input  logic            stpclk_n,
  input  logic            slp_n,
  input  logic            dpslp_n,
  input  logic            dprst_n,
  output logic [1:0]      vcode,
  output logic            pll_en,
  output logic [NTHR-1:0] save_stb,
  output logic [NTHR-1:0] restore_stb,
  output logic            core_rst,
  output logic            snoop_ok,
  output logic            proto_err
);
  localparam int CMAX = (RST_CYC > NTHR) ? RST_CYC : NTHR;
  localparam int CW   = $clog2(CMAX + 1);

  dpd_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    lvl;
  logic          pin_bad;
  logic          elig;
  logic          save_en, rest_en;

  dpd_pin_track u_pins (
    .clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n),
    .dpslp_n(dpslp_n), .dprst_n(dprst_n), .lvl(lvl), .pin_bad(pin_bad),
    .proto_err(proto_err)
  );

  dpd_elig #(.NTHR(NTHR), .WAYW(WAYW)) u_elig (
    .thr_deep(thr_deep), .l2_ways(l2_ways), .elig(elig)
  );

  assign save_en = (st_q == ST_SAVE) && elig;
  assign rest_en = (st_q == ST_RESTORE) && (cnt_q < CW'(NTHR));

  dpd_thr_strobe #(.NTHR(NTHR), .CW(CW)) u_save (
    .en(save_en), .idx(cnt_q), .stb(save_stb)
  );
  dpd_thr_strobe #(.NTHR(NTHR), .CW(CW)) u_rest (
    .en(rest_en), .idx(cnt_q), .stb(restore_stb)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_C0: if (elig) begin
        st_d  = ST_SAVE;
        cnt_d = '0;
      end
      ST_SAVE: begin
        if (!elig) st_d = ST_C0;
        else if (cnt_q == CW'(NTHR - 1)) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end else cnt_d = cnt_q + CW'(1);
      end
      ST_WAIT: begin
        if (lvl == LV_ALL) st_d = ST_PKG;
        else if (!elig)    st_d = ST_C0;
      end
      ST_PKG:   if (lvl <= LV_SLP) st_d = ST_VRAMP;
      ST_VRAMP: if (lvl <= LV_STP) begin
        st_d  = ST_RESET;
        cnt_d = '0;
      end
      ST_RESET: begin
        if (cnt_q == CW'(RST_CYC - 1)) begin
          st_d  = ST_RESTORE;
          cnt_d = '0;
        end else cnt_d = cnt_q + CW'(1);
      end
      ST_RESTORE: begin
        if (cnt_q < CW'(NTHR)) cnt_d = cnt_q + CW'(1);
        else if (lvl == LV_NONE) st_d = ST_C0;
      end
      default: st_d = ST_C0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_C0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign vcode    = vcode_of(st_q);
  assign pll_en   = (st_q != ST_PKG);
  assign core_rst = (st_q == ST_RESET);
  assign snoop_ok = !(st_q inside {ST_PKG, ST_VRAMP, ST_RESET});

  a_r1_entry_needs_elig: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SAVE && $past(st_q) == ST_C0) |-> $past(elig));
  a_r4_deep_after_dprst: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PKG && $past(st_q) != ST_PKG) |-> $past(lvl) == LV_ALL);
  a_r5_abort_before_dprst: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_C0 && $past(st_q) == ST_WAIT) |-> $past(lvl) != LV_ALL);
  a_r6_pll_up_on_dpslp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(lvl) <= LV_SLP);
  a_r7_restore_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|restore_stb) |-> $past(core_rst));
  a_r7_restore_t0_first: assert property (@(posedge clk) disable iff (!rst_n)
    restore_stb[NTHR-1] |-> (NTHR == 1) || $past(restore_stb[0]));
  a_r9_quiet_while_rst: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !snoop_ok);
endmodule

// File: tb/pkg_dpd_seq_tb.sv
module pkg_dpd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 2;
  localparam int WAYW = 4;
  localparam int RST_CYC = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NTHR-1:0] thr_deep;
  logic [WAYW-1:0] l2_ways;
  logic [3:0]      asrt;   // bit0 stop-clock .. bit3 deep-reset, 1 = asserted
  logic [1:0]      vcode;
  logic            pll_en, core_rst, snoop_ok, proto_err;
  logic [NTHR-1:0] save_stb, restore_stb;
  int nvec = 0;
  int nbad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pkg_dpd_seq #(.NTHR(NTHR), .WAYW(WAYW), .RST_CYC(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_deep(thr_deep), .l2_ways(l2_ways),
    .stpclk_n(~asrt[0]), .slp_n(~asrt[1]), .dpslp_n(~asrt[2]), .dprst_n(~asrt[3]),
    .vcode(vcode), .pll_en(pll_en), .save_stb(save_stb), .restore_stb(restore_stb),
    .core_rst(core_rst), .snoop_ok(snoop_ok), .proto_err(proto_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; asrt = 4'b0; thr_deep = '0; l2_ways = 4'hF;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  // thermometer of k asserted pins, built by shifting
  function automatic logic [3:0] therm(input int k);
    logic [3:0] t = 4'b0;
    for (int i = 0; i < k; i++) t = {t[2:0], 1'b1};
    return t;
  endfunction

  // enter and finish the save, then assert pins up to level k
  task automatic enter_to(input int k);
    thr_deep = '1; l2_ways = '0;
    step(NTHR + 1);
    for (int i = 1; i <= k; i++) begin
      asrt = therm(i);
      step(1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nbad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    do_reset();
    // R2 reset state
    chk("R2 vcode", vcode, 2); chk("R2 pll_en", pll_en, 1);
    chk("R2 snoop_ok", snoop_ok, 1); chk("R2 core_rst", core_rst, 0);
    chk("R2 save", save_stb, 0); chk("R2 restore", restore_stb, 0);
    chk("R2 proto_err", proto_err, 0);

    // R1 / R5 sweep over thread flags and way counts
    for (int t = 0; t < (1 << NTHR); t++) begin
      for (int w = 0; w < (1 << WAYW); w++) begin
        thr_deep = NTHR'(t); l2_ways = WAYW'(w);
        step(1);
        chk("R1 save t0", save_stb, (t == (1 << NTHR) - 1 && w == 0) ? 1 : 0);
        thr_deep = '0; l2_ways = 4'hF;
        step(1);
        chk("R5 abort restore", restore_stb, 0);
        chk("R5 abort vcode", vcode, 2);
        chk("R5 abort save", save_stb, 0);
      end
    end

    // R3 sweep: every pin pattern applied from the idle level
    for (int p = 0; p < 16; p++) begin
      do_reset();
      asrt = 4'(p);
      step(1);
      chk("R3 proto_err", proto_err,
          (((p & (p + 1)) == 0) && ($countones(4'(p)) <= 1)) ? 0 : 1);
      asrt = 4'b0;
      step(1);
      chk("R3 no entry", vcode, 2);
    end

    // Main sequence: entry, illegal pin during the deep state, exit
    do_reset();
    thr_deep = '1; l2_ways = '0;
    step(1); chk("R1 save t0", save_stb, 1);
    step(1); chk("R1 save t1", save_stb, 2);
    step(1); chk("R1 save done", save_stb, 0);
    for (int i = 1; i <= 3; i++) begin
      asrt = therm(i); step(1);
      chk("R4 not yet deep", vcode, 2);
    end
    asrt = therm(4); step(2);
    chk("R4 vcode min", vcode, 0); chk("R4 pll off", pll_en, 0);
    chk("R9 snoop off", snoop_ok, 0);
    thr_deep = '0;
    asrt = therm(3); step(2);
    chk("R6 dprst release only", vcode, 0);
    asrt = 4'b0101; step(1);
    chk("R3 err in deep", proto_err, 1);
    step(1); chk("R3 hold state", vcode, 0);
    asrt = therm(3); step(2);
    chk("R3 still deep", vcode, 0);
    asrt = therm(2); step(2);
    chk("R6 vcode lfm", vcode, 1); chk("R6 pll on", pll_en, 1);
    chk("R9 snoop off vramp", snoop_ok, 0);
    asrt = therm(1); step(2);
    for (int c = 0; c < RST_CYC; c++) begin
      chk("R7 core_rst high", core_rst, 1);
      chk("R9 snoop off rst", snoop_ok, 0);
      chk("R7 no restore yet", restore_stb, 0);
      step(1);
    end
    chk("R7 core_rst low", core_rst, 0); chk("R7 restore t0", restore_stb, 1);
    chk("R9 snoop back", snoop_ok, 1);
    step(1); chk("R7 restore t1", restore_stb, 2);
    step(1); chk("R7 restore done", restore_stb, 0);
    chk("R8 still lfm", vcode, 1);
    asrt = 4'b0; step(2);
    chk("R8 vcode normal", vcode, 2); chk("R8 snoop", snoop_ok, 1);
    chk("R3 sticky", proto_err, 1);

    // R5 abort in the pin wait, then pins alone do not enter
    do_reset();
    enter_to(2);
    l2_ways = 4'd1; step(1);
    asrt = therm(3); step(1);
    asrt = therm(4); step(2);
    chk("R5 no deep", vcode, 2); chk("R5 no restore", restore_stb, 0);
    chk("R5 snoop", snoop_ok, 1);

    // R10 case A: registered deep-reset level meets the eligibility loss
    do_reset();
    enter_to(3);
    asrt = therm(4); step(1);
    thr_deep = '0; step(1);
    chk("R10 entry wins", vcode, 0); chk("R10 snoop off", snoop_ok, 0);

    // R10 case B: eligibility drops with the pin change itself
    do_reset();
    enter_to(3);
    asrt = therm(4); thr_deep = '0; step(2);
    chk("R10 abort wins", vcode, 2); chk("R10 snoop on", snoop_ok, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule